// File: doc/BRIEF.md
# Serial Display Command and Pixel Receiver

This block sits behind the serial pins of a display controller and turns the incoming bit stream into register-index writes, 16-bit register parameter writes and 16-bit pixel writes. Its clock is the serial clock itself. Each output is a one-cycle strobe with its value held on a bus, so the register file or the display memory port that takes the words can latch them directly.

Two framings are supported, and an input selects between them. With the flag-in-frame framing, every frame is nine bits long and its first bit tells command from data. With the flag-on-pin framing, every frame is eight bits long and a separate select pin carries the command/data flag. A command byte becomes the current register index. Data bytes are paired into words, first byte high. A word is routed to the pixel strobe when the current index is the memory-write index. Otherwise it goes to the parameter strobe.

The frame receiver is a three-state machine. FR_IDLE is the reset state. In it, bits are ignored until chip select has been seen high. FR_FLAG expects the command/data bit of a nine-bit frame. FR_BITS shifts in the eight byte bits. Any cycle with chip select high moves the receiver to FR_FLAG or FR_BITS according to the mode input (transition "arm"). FR_FLAG always goes to FR_BITS (transition "flag taken"). FR_BITS returns to FR_FLAG or stays in FR_BITS on its eighth bit (transition "byte done"). The word assembler has two states. PR_HI waits for a high byte and goes to PR_LO on a data byte ("high taken"). PR_LO waits for a low byte and returns to PR_HI on a data byte ("word out"). A command byte sends either state to PR_HI ("index set").

Top module: `lcd_spi_rx`

## Requirements
- R1: After reset every strobe is low, `reg_idx`, `wr_word` and `wr_tag` are zero, and the word assembler expects a high byte.
- R2: With `three_wire` = 1, a frame is nine bits. The first bit is the flag (0 = command, 1 = data) and the next eight are the byte, most significant bit first.
- R3: With `three_wire` = 0, a frame is eight bits, most significant bit first. The flag is `dc_sel` (0 = command, 1 = data), sampled on the same rising edge as the eighth bit.
- R4: Bits are sampled on rising `sclk` edges while `cs_n` is low. A cycle with `cs_n` high discards any partial frame and restarts the bit count.
- R5: `three_wire` is taken only on edges where `cs_n` is high. A change while `cs_n` is low has no effect on the frame in progress.
- R6: A command byte drives `reg_idx_we` high for exactly one cycle, in the cycle after the edge that follows the one sampling the last bit. From then on `reg_idx` holds the byte.
- R7: A command byte discards an unpaired data byte, so the next data byte is taken as the high byte.
- R8: Two data bytes produce one word {first, second} on `wr_word`, with one strobe for one cycle (same timing as R6) and `wr_tag` equal to `reg_idx` at that moment.
- R9: The word strobe is `pix_we` when the index equals `PIX_IDX` (default 0x22) and `prm_we` otherwise. The two strobes are never high together.
- R10: Byte pairing persists across chip-select windows, so a word may span two windows.
- R11: Frames may follow each other back to back within one chip-select window, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low chip select framing the transfers |
| sdi | input | 1 | Serial data in, MSB first |
| dc_sel | input | 1 | Command(0)/data(1) flag pin for the eight-bit framing |
| three_wire | input | 1 | 1 = nine-bit framing with flag in frame, 0 = eight-bit framing |
| reg_idx_we | output | 1 | One-cycle strobe for a register-index write |
| reg_idx | output | 8 | Current register index |
| prm_we | output | 1 | One-cycle strobe for a register parameter word |
| pix_we | output | 1 | One-cycle strobe for a pixel word |
| wr_word | output | 16 | Last assembled word, high byte first |
| wr_tag | output | 8 | Register index the last word belongs to |

## Verification
Two functions share a cycle whenever frames run back to back. The word or index strobe from one frame goes out while the first bits of the next frame are being shifted in, and in the flag-in-frame framing that includes the flag capture. Long single chip-select windows of mixed commands and data provoke this, as do mode changes and aborted frames set right before the next frame starts. A behavioural model in the bench predicts every strobe, index, word and tag, and these are compared on every clock. Directed checks of the final word, tag and strobe counts follow each scenario.

// File: rtl/lcd_spi_pkg.sv
package lcd_spi_pkg;

    // frame receiver states
    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_FLAG = 2'd1,
        FR_BITS = 2'd2
    } fr_state_t;

    // word assembler states
    typedef enum logic {
        PR_HI = 1'b0,
        PR_LO = 1'b1
    } pr_state_t;

    localparam logic FLAG_CMD  = 1'b0;
    localparam logic FLAG_DATA = 1'b1;

endpackage

// File: rtl/lcd_spi_frame.sv
module lcd_spi_frame
    import lcd_spi_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sdi,
    input  logic              dc_sel,
    input  logic              three_wire,
    output logic              byte_vld,
    output logic              byte_dc,
    output logic [BYTE_W-1:0] byte_q
);

    localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    fr_state_t         st_q, st_d;
    logic              mode_q;
    logic              flag_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] sh_q;
    logic [BYTE_W-1:0] sh_next;

    assign sh_next = {sh_q[BYTE_W-2:0], sdi};

    // state register
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= FR_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (cs_n) begin
            st_d = three_wire ? FR_FLAG : FR_BITS;          // arm
        end else begin
            unique case (st_q)
                FR_IDLE: st_d = FR_IDLE;
                FR_FLAG: st_d = FR_BITS;                    // flag taken
                FR_BITS: begin
                    if (cnt_q == LAST_BIT) begin            // byte done
                        st_d = mode_q ? FR_FLAG : FR_BITS;
                    end
                end
                default: st_d = FR_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= 1'b0;
            flag_q   <= FLAG_CMD;
            cnt_q    <= '0;
            sh_q     <= '0;
            byte_vld <= 1'b0;
            byte_dc  <= FLAG_CMD;
            byte_q   <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (cs_n) begin
                mode_q <= three_wire;
                cnt_q  <= '0;
            end else begin
                unique case (st_q)
                    FR_IDLE: begin
                        cnt_q <= '0;
                    end
                    FR_FLAG: begin
                        flag_q <= sdi;
                    end
                    FR_BITS: begin
                        sh_q <= sh_next;
                        if (cnt_q == LAST_BIT) begin
                            cnt_q    <= '0;
                            byte_vld <= 1'b1;
                            byte_q   <= sh_next;
                            byte_dc  <= mode_q ? flag_q : dc_sel;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: begin
                        cnt_q <= '0;
                    end
                endcase
            end
        end
    end

    // R4
    frame_abort_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        cs_n |=> !byte_vld);

    // R11
    byte_spacing_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);

    // R2
    flag_then_bits_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (st_q == FR_FLAG && !cs_n) |=> (st_q == FR_BITS && !byte_vld));

endmodule

// File: rtl/lcd_spi_pair.sv
module lcd_spi_pair
    import lcd_spi_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int PIX_IDX = 34
) (
    input  logic                sclk,
    input  logic                rst_n,
    input  logic                byte_vld,
    input  logic                byte_dc,
    input  logic [BYTE_W-1:0]   byte_q,
    output logic                idx_we,
    output logic [BYTE_W-1:0]   idx_q,
    output logic                prm_we,
    output logic                pix_we,
    output logic [2*BYTE_W-1:0] word_q,
    output logic [BYTE_W-1:0]   tag_q
);

    localparam logic [BYTE_W-1:0] PIX_CODE = BYTE_W'(PIX_IDX);

    pr_state_t         ps_q, ps_d;
    logic [BYTE_W-1:0] hi_q;

    // state register
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= PR_HI;
        end else begin
            ps_q <= ps_d;
        end
    end

    // next state
    always_comb begin
        ps_d = ps_q;
        if (byte_vld) begin
            if (byte_dc == FLAG_CMD) begin
                ps_d = PR_HI;                               // index set
            end else begin
                unique case (ps_q)
                    PR_HI: ps_d = PR_LO;                    // high taken
                    PR_LO: ps_d = PR_HI;                    // word out
                    default: ps_d = PR_HI;
                endcase
            end
        end
    end

    // outputs
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            idx_we <= 1'b0;
            idx_q  <= '0;
            prm_we <= 1'b0;
            pix_we <= 1'b0;
            word_q <= '0;
            tag_q  <= '0;
            hi_q   <= '0;
        end else begin
            idx_we <= 1'b0;
            prm_we <= 1'b0;
            pix_we <= 1'b0;
            if (byte_vld) begin
                if (byte_dc == FLAG_CMD) begin
                    idx_q  <= byte_q;
                    idx_we <= 1'b1;
                end else begin
                    unique case (ps_q)
                        PR_HI: begin
                            hi_q <= byte_q;
                        end
                        PR_LO: begin
                            word_q <= {hi_q, byte_q};
                            tag_q  <= idx_q;
                            if (idx_q == PIX_CODE) begin
                                pix_we <= 1'b1;
                            end else begin
                                prm_we <= 1'b1;
                            end
                        end
                        default: begin
                            hi_q <= hi_q;
                        end
                    endcase
                end
            end
        end
    end

    // R9
    one_route_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        $onehot0({idx_we, prm_we, pix_we}));

    // R8
    word_from_data_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (prm_we || pix_we) |-> $past(byte_vld && byte_dc == FLAG_DATA));

    // R6
    index_from_cmd_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        idx_we |-> $past(byte_vld && byte_dc == FLAG_CMD));

    // R7
    cmd_clears_pair_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (byte_vld && byte_dc == FLAG_CMD) |=> (ps_q == PR_HI));

endmodule

// File: rtl/lcd_spi_rx.sv
module lcd_spi_rx
    import lcd_spi_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int PIX_IDX = 34
) (
    input  logic                sclk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                sdi,
    input  logic                dc_sel,
    input  logic                three_wire,
    output logic                reg_idx_we,
    output logic [BYTE_W-1:0]   reg_idx,
    output logic                prm_we,
    output logic                pix_we,
    output logic [2*BYTE_W-1:0] wr_word,
    output logic [BYTE_W-1:0]   wr_tag
);

    logic              fb_vld;
    logic              fb_dc;
    logic [BYTE_W-1:0] fb_byte;

    lcd_spi_frame #(
        .BYTE_W (BYTE_W)
    ) u_frame (
        .sclk       (sclk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sdi        (sdi),
        .dc_sel     (dc_sel),
        .three_wire (three_wire),
        .byte_vld   (fb_vld),
        .byte_dc    (fb_dc),
        .byte_q     (fb_byte)
    );

    lcd_spi_pair #(
        .BYTE_W  (BYTE_W),
        .PIX_IDX (PIX_IDX)
    ) u_pair (
        .sclk     (sclk),
        .rst_n    (rst_n),
        .byte_vld (fb_vld),
        .byte_dc  (fb_dc),
        .byte_q   (fb_byte),
        .idx_we   (reg_idx_we),
        .idx_q    (reg_idx),
        .prm_we   (prm_we),
        .pix_we   (pix_we),
        .word_q   (wr_word),
        .tag_q    (wr_tag)
    );

    // R6
    index_follows_strobe_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        reg_idx_we |=> (!reg_idx_we && $stable(reg_idx)));

    // R8
    tag_matches_index_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (prm_we || pix_we) |-> (wr_tag == reg_idx));

endmodule

// File: tb/lcd_spi_rx_bench.sv
`timescale 1ns/1ps
module lcd_spi_rx_bench;

    logic        sclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sdi = 1'b0;
    logic        dc_sel = 1'b0;
    logic        three_wire = 1'b0;
    logic        reg_idx_we;
    logic [7:0]  reg_idx;
    logic        prm_we;
    logic        pix_we;
    logic [15:0] wr_word;
    logic [7:0]  wr_tag;

    int checks = 0;
    int fails  = 0;
    int n_prm  = 0;
    int n_pix  = 0;
    int n_idx  = 0;
    string req = "R1";

    always #4 sclk = ~sclk;

    lcd_spi_rx u_lcd_spi_rx (
        .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi), .dc_sel(dc_sel),
        .three_wire(three_wire), .reg_idx_we(reg_idx_we), .reg_idx(reg_idx),
        .prm_we(prm_we), .pix_we(pix_we), .wr_word(wr_word), .wr_tag(wr_tag)
    );

    // behavioural reference model
    int         m_nbits = 0;
    bit         m_mode = 0, m_live = 0, m_flag = 0;
    bit [7:0]   m_acc = 0, m_idx = 0, m_hi = 0;
    bit         m_have_hi = 0;
    bit         bev = 0, bdc = 0;
    bit [7:0]   bbyte = 0;
    bit         e_iwe = 0, e_prm = 0, e_pix = 0;
    bit [15:0]  e_word = 0;
    bit [7:0]   e_tag = 0;

    always @(posedge sclk) begin
        if (!rst_n) begin
            m_nbits = 0; m_mode = 0; m_live = 0; m_idx = 0; m_have_hi = 0;
            bev = 0; e_iwe = 0; e_prm = 0; e_pix = 0; e_word = 0; e_tag = 0;
        end else begin
            e_iwe = 0; e_prm = 0; e_pix = 0;
            if (bev) begin
                if (!bdc) begin
                    m_idx = bbyte; e_iwe = 1; m_have_hi = 0;
                end else if (!m_have_hi) begin
                    m_hi = bbyte; m_have_hi = 1;
                end else begin
                    e_word = {m_hi, bbyte}; e_tag = m_idx; m_have_hi = 0;
                    if (m_idx == 8'h22) e_pix = 1; else e_prm = 1;
                end
            end
            bev = 0;
            if (cs_n) begin
                m_mode = three_wire; m_nbits = 0; m_live = 1;
            end else if (m_live) begin
                if (m_mode && m_nbits == 0) begin
                    m_flag = sdi; m_nbits = 1;
                end else begin
                    m_acc = {m_acc[6:0], sdi};
                    m_nbits++;
                    if (m_nbits == (m_mode ? 9 : 8)) begin
                        bev = 1; bbyte = m_acc; bdc = m_mode ? m_flag : dc_sel;
                        m_nbits = 0;
                    end
                end
            end
        end
    end

    task automatic check(input string r, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", r, what, act, exp, $time);
        end
    endtask

    // compare against the model on every clock, away from the edge
    always @(negedge sclk) begin
        if (rst_n) begin
            check(req, "R6 idx strobe", reg_idx_we, e_iwe);
            check(req, "R6 index", reg_idx, m_idx);
            check(req, "R9 prm strobe", prm_we, e_prm);
            check(req, "R9 pix strobe", pix_we, e_pix);
            check(req, "R8 word", wr_word, e_word);
            check(req, "R8 tag", wr_tag, e_tag);
            if (prm_we) n_prm++;
            if (pix_we) n_pix++;
            if (reg_idx_we) n_idx++;
        end
    end

    task automatic drive_bit(input logic b);
        @(negedge sclk);
        cs_n = 1'b0;
        sdi  = b;
    endtask

    task automatic send(input logic dc, input logic [7:0] b);
        if (three_wire) begin
            drive_bit(dc);
        end else begin
            @(negedge sclk);
            cs_n = 1'b0; dc_sel = dc; sdi = b[7];
            for (int i = 6; i >= 0; i--) drive_bit(b[i]);
            return;
        end
        for (int i = 7; i >= 0; i--) drive_bit(b[i]);
    endtask

    task automatic cs_release(input logic mode);
        @(negedge sclk);
        cs_n = 1'b1;
        three_wire = mode;
        repeat (3) @(negedge sclk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge sclk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        int p0, x0;
        repeat (3) @(negedge sclk);
        // R1 reset state
        check("R1", "idx_we", reg_idx_we, 0);
        check("R1", "prm_we", prm_we, 0);
        check("R1", "pix_we", pix_we, 0);
        check("R1", "reg_idx", reg_idx, 0);
        check("R1", "wr_word", wr_word, 0);
        @(negedge sclk); rst_n = 1'b1;
        repeat (2) @(negedge sclk);

        // R3 eight-bit framing with flag pin
        req = "R3"; three_wire = 0; repeat (2) @(negedge sclk);
        send(0, 8'h11); send(1, 8'hAB); send(1, 8'hCD); cs_release(0);
        check("R3", "word", wr_word, 16'hABCD);
        check("R3", "tag", wr_tag, 8'h11);
        check("R3", "prm count", n_prm, 1);

        // R9 pixel routing
        req = "R9";
        send(0, 8'h22); send(1, 8'h12); send(1, 8'h34); send(1, 8'h56); send(1, 8'h78);
        cs_release(1);
        check("R9", "pix count", n_pix, 2);
        check("R9", "prm count", n_prm, 1);
        check("R9", "word", wr_word, 16'h5678);

        // R2 nine-bit framing with flag in frame
        req = "R2";
        send(0, 8'h30); send(1, 8'hBE); send(1, 8'hEF); cs_release(1);
        check("R2", "word", wr_word, 16'hBEEF);
        check("R2", "tag", wr_tag, 8'h30);

        // R4 aborted partial frame
        req = "R4";
        p0 = n_prm; x0 = n_idx;
        drive_bit(0); drive_bit(1); drive_bit(1); drive_bit(0); drive_bit(1);
        cs_release(1);
        check("R4", "no strobe after abort", n_idx + n_prm + n_pix, x0 + p0 + 2);
        send(1, 8'h01); send(1, 8'h02); cs_release(1);
        check("R4", "word after abort", wr_word, 16'h0102);
        check("R4", "index kept", reg_idx, 8'h30);

        // R7 command drops the lone high byte
        req = "R7";
        send(1, 8'h99); send(0, 8'h31); send(1, 8'h0A); send(1, 8'h0B); cs_release(0);
        check("R7", "word", wr_word, 16'h0A0B);
        check("R7", "tag", wr_tag, 8'h31);

        // R5 mode change while selected is ignored
        req = "R5";
        dc_sel = 0;
        for (int i = 7; i >= 0; i--) begin
            drive_bit(i[0] ? 1'b0 : (8'h40 >> i) & 1);
            if (i == 7) sdi = 1'b0;
            if (i == 4) three_wire = 1'b1;
        end
        cs_release(0);
        check("R5", "index from 8-bit frame", reg_idx, 8'h40);

        // R10 pairing across windows, R11 back-to-back frames
        req = "R10"; three_wire = 1; repeat (2) @(negedge sclk);
        x0 = n_pix;
        send(0, 8'h22); send(1, 8'hF0); cs_release(1);
        send(1, 8'h0F); cs_release(1);
        check("R10", "word", wr_word, 16'hF00F);
        req = "R11";
        send(1, 8'hA1); send(1, 8'hA2); send(1, 8'hA3); send(1, 8'hA4); cs_release(1);
        check("R11", "pix count", n_pix, x0 + 3);
        check("R11", "word", wr_word, 16'hA3A4);

        // R8 mixed random traffic, compared against the model every clock
        req = "R8";
        for (int g = 0; g < 12; g++) begin
            for (int k = 0; k < 5; k++) begin
                logic [7:0] rb;
                logic rdc;
                rb  = 8'($urandom);
                rdc = ($urandom % 4) != 0;
                if (($urandom % 3) == 0) rb = 8'h22;
                send(rdc, rb);
            end
            cs_release(1'($urandom));
        end
        repeat (4) @(negedge sclk);
        summary();
    end

endmodule